// File: doc/BRIEF.md
# Outer-Product Integer Multiply-Accumulate Grid

The block is an 8 by 8 grid of 32-bit accumulators fed as an outer product. Each cycle it may take one wide operand and one narrow operand, both 256 bits. The wide operand holds eight column lanes of weights. The narrow operand holds eight row lanes, one per batch. Every lane carries four signed 8-bit values.

When an operand pair is accepted, the cell at row r and column c forms a four-term signed dot product of narrow lane r with wide lane c. It adds that result into its own accumulator. All 64 cells update in the same cycle.

A clear command zeroes the whole grid. A read port returns one full row of accumulators, eight 32-bit words, on the cycle after the request. This lets the results be drained one row at a time after a run of accumulations. Operand fetch, register storage and rescaling of results are handled outside the block.

Top module: `opmac_grid`

## Requirements
- R1: Each 8-bit element is a signed two's-complement value. A cell's increment is the sum of four products, each product sign-extended, where element k of a lane occupies bits [8k+7:8k] of that lane.
- R2: When valid_i is high and clear_i is low at a rising edge, accumulator (r,c) adds the dot product of narrow lane r with wide lane c. Lane j occupies bits [32j+31:32j] of its operand bus.
- R3: When clear_i is high at a rising edge, all 64 accumulators become zero at that edge, even when valid_i is high in the same cycle.
- R4: When valid_i and clear_i are both low at an edge, no accumulator changes, whatever the operand buses carry.
- R5: Accumulation wraps modulo 2^32 and never saturates.
- R6: A read request (rd_en_i high, rd_row_i = r) at an edge gives rd_valid_o = 1 in the following cycle. In that cycle rd_data_o holds row r as it stood before that edge, with column c in bits [32c+31:32c]. Without a request, rd_valid_o is 0 in the next cycle and rd_data_o keeps its value.
- R7: After reset, all accumulators are zero, rd_valid_o is 0 and rd_data_o is zero.
- R8: An operand pair accepted at one edge is visible to a read request made at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair valid, accumulate this cycle |
| wide_i | input | 256 | Weight operand, eight column lanes of four int8 |
| narrow_i | input | 256 | Batch operand, eight row lanes of four int8 |
| clear_i | input | 1 | Zero all accumulators, wins over valid_i |
| rd_en_i | input | 1 | Row read request |
| rd_row_i | input | 3 | Row index to read |
| rd_valid_o | output | 1 | Row data valid |
| rd_data_o | output | 256 | Eight 32-bit accumulators of the requested row |

## Verification
The grid is driven from a table that mixes two kinds of operands: pseudo-random byte patterns and constant fills of 0x80, 0x7F, 0x00 and 0xFF. The random patterns catch swapped lanes, swapped rows and columns, and swapped element order. The constant fills pin down sign handling: -128 times -128 gives the largest positive product and -128 times 127 the most negative. Directed tests then check four things:
- an accumulate and a read in the same cycle, which tells the pre-update row from the post-update row;
- a clear raised together with valid;
- idle cycles with noisy operand buses;
- a long run of maximum products that crosses 2^31, which tells wrapping from saturation.

// File: rtl/opmac_pkg.sv
package opmac_pkg;
  localparam int unsigned OPMAC_EW    = 8;
  localparam int unsigned OPMAC_LANES = 4;
  localparam int unsigned OPMAC_AW    = 32;
  localparam int unsigned OPMAC_ROWS  = 8;
  localparam int unsigned OPMAC_COLS  = 8;

  // width of a signed dot product of n lanes of ew-bit operands
  function automatic int unsigned dot_width(int unsigned ew, int unsigned n);
    return 2 * ew + $clog2(n);
  endfunction
endpackage

// File: rtl/opmac_dot4.sv
module opmac_dot4
  import opmac_pkg::*;
#(
  parameter int unsigned EW    = OPMAC_EW,
  parameter int unsigned LANES = OPMAC_LANES,
  localparam int unsigned LW   = EW * LANES,
  localparam int unsigned PW   = 2 * EW,
  localparam int unsigned SW   = dot_width(EW, LANES)
) (
  input  logic [LW-1:0]        a_i,
  input  logic [LW-1:0]        b_i,
  output logic signed [SW-1:0] dot_o
);
  logic signed [PW-1:0] prod [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [PW-1:0] ax, bx;
    assign ax      = PW'($signed(a_i[k*EW +: EW]));
    assign bx      = PW'($signed(b_i[k*EW +: EW]));
    assign prod[k] = ax * bx;
  end

  always_comb begin
    dot_o = '0;
    for (int k = 0; k < LANES; k++) dot_o = dot_o + SW'(prod[k]);
  end
endmodule

// File: rtl/opmac_cell.sv
module opmac_cell
  import opmac_pkg::*;
#(
  parameter int unsigned EW    = OPMAC_EW,
  parameter int unsigned LANES = OPMAC_LANES,
  parameter int unsigned AW    = OPMAC_AW,
  localparam int unsigned LW   = EW * LANES,
  localparam int unsigned SW   = dot_width(EW, LANES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_en_i,
  input  logic          clr_i,
  input  logic [LW-1:0] a_i,
  input  logic [LW-1:0] b_i,
  output logic [AW-1:0] acc_o
);
  localparam int DOT_LIM = int'(LANES) * (1 << (2 * EW - 2));

  logic signed [SW-1:0] dot;
  logic [AW-1:0]        acc_q;

  opmac_dot4 #(.EW(EW), .LANES(LANES)) u_dot (
    .a_i  (a_i),
    .b_i  (b_i),
    .dot_o(dot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (clr_i)    acc_q <= '0;
    else if (acc_en_i) acc_q <= acc_q + {{(AW-SW){dot[SW-1]}}, dot};  // wraps
  end

  assign acc_o = acc_q;

  AST_DOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i |-> (int'(dot) <= DOT_LIM && int'(dot) >= -DOT_LIM)); // R1
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_o == '0); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !acc_en_i) |=> $stable(acc_o)); // R4
endmodule

// File: rtl/opmac_readout.sv
module opmac_readout
  import opmac_pkg::*;
#(
  parameter int unsigned AW   = OPMAC_AW,
  parameter int unsigned ROWS = OPMAC_ROWS,
  parameter int unsigned COLS = OPMAC_COLS,
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned ROW_BW = AW * COLS
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ROWS*ROW_BW-1:0] acc_i,
  input  logic                   rd_en_i,
  input  logic [ROW_W-1:0]       rd_row_i,
  output logic                   rd_valid_o,
  output logic [ROW_BW-1:0]      rd_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= acc_i[int'(rd_row_i)*ROW_BW +: ROW_BW];
    end
  end

  AST_RD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o); // R6
  AST_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (!rd_valid_o && $stable(rd_data_o))); // R6
endmodule

// File: rtl/opmac_grid.sv
module opmac_grid
  import opmac_pkg::*;
#(
  parameter int unsigned EW    = OPMAC_EW,
  parameter int unsigned LANES = OPMAC_LANES,
  parameter int unsigned AW    = OPMAC_AW,
  parameter int unsigned ROWS  = OPMAC_ROWS,
  parameter int unsigned COLS  = OPMAC_COLS,
  localparam int unsigned LW    = EW * LANES,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [COLS*LW-1:0]   wide_i,
  input  logic [ROWS*LW-1:0]   narrow_i,
  input  logic                 clear_i,
  input  logic                 rd_en_i,
  input  logic [ROW_W-1:0]     rd_row_i,
  output logic                 rd_valid_o,
  output logic [COLS*AW-1:0]   rd_data_o
);
  logic [ROWS*COLS*AW-1:0] acc_all;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      opmac_cell #(.EW(EW), .LANES(LANES), .AW(AW)) u_cell (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .acc_en_i(valid_i),
        .clr_i   (clear_i),
        .a_i     (narrow_i[r*LW +: LW]),
        .b_i     (wide_i[c*LW +: LW]),
        .acc_o   (acc_all[(r*COLS+c)*AW +: AW])
      );
    end
  end

  opmac_readout #(.AW(AW), .ROWS(ROWS), .COLS(COLS)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc_all),
    .rd_en_i   (rd_en_i),
    .rd_row_i  (rd_row_i),
    .rd_valid_o(rd_valid_o),
    .rd_data_o (rd_data_o)
  );

  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && valid_i) |=> acc_all == '0); // R3
endmodule

// File: tb/opmac_grid_test.sv
module opmac_grid_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 6;
  // per entry: wide kind/seed, narrow kind/seed; kind 1 = constant byte fill
  localparam bit          W_KIND [N_VEC] = '{0, 1, 1, 0, 1, 1};
  localparam logic [31:0] W_SEED [N_VEC] = '{32'h1234, 32'h80, 32'h80, 32'h5a17, 32'h00, 32'hff};
  localparam bit          N_KIND [N_VEC] = '{0, 1, 1, 0, 0, 0};
  localparam logic [31:0] N_SEED [N_VEC] = '{32'h9876, 32'h80, 32'h7f, 32'hc3d1, 32'h4242, 32'h0707};

  logic clk = 0, rst_n = 0, valid = 0, clear = 0, rd_en = 0;
  logic [255:0] wide = '0, narrow = '0;
  logic [2:0] rd_row = '0;
  logic rd_valid;
  logic [255:0] rd_data;
  logic [31:0] model [8][8];
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opmac_grid uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .wide_i(wide), .narrow_i(narrow),
    .clear_i(clear), .rd_en_i(rd_en), .rd_row_i(rd_row),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  function automatic logic [255:0] gen_vec(bit kind, logic [31:0] seed);
    logic [255:0] v;
    logic [31:0] h = seed;
    for (int i = 0; i < 32; i++) begin
      h = h * 32'd1103515245 + 32'd12345;
      v[i*8 +: 8] = kind ? seed[7:0] : h[23:16];
    end
    return v;
  endfunction

  function automatic logic [31:0] ref_dot(logic [31:0] a, logic [31:0] b);
    int s = 0;
    for (int k = 0; k < 4; k++)
      s += int'($signed(a[k*8 +: 8])) * int'($signed(b[k*8 +: 8]));
    return 32'(s);
  endfunction

  function automatic logic [255:0] model_row(int r);
    logic [255:0] v;
    for (int c = 0; c < 8; c++) v[c*32 +: 32] = model[r][c];
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_acc(logic [255:0] w, logic [255:0] n);
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        model[r][c] = model[r][c] + ref_dot(n[r*32 +: 32], w[c*32 +: 32]);
  endtask

  // starts and ends at a falling edge
  task automatic accumulate(logic [255:0] w, logic [255:0] n);
    valid = 1; wide = w; narrow = n;
    @(posedge clk); @(negedge clk);
    valid = 0;
    model_acc(w, n);
  endtask

  task automatic read_row(int r, string req);
    rd_en = 1; rd_row = 3'(r);
    @(posedge clk); @(negedge clk);
    rd_en = 0;
    check(rd_valid === 1'b1 && rd_data === model_row(r), req, rd_data, model_row(r));
  endtask

  task automatic read_all(string req);
    for (int r = 0; r < 8; r++) read_row(r, req);
  endtask

  initial begin
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) model[r][c] = '0;
    repeat (2) @(negedge clk);
    check(rd_valid === 1'b0 && rd_data === '0, "R7 reset outputs", {255'd0, rd_valid}, '0);
    rst_n = 1;
    @(negedge clk);
    read_all("R7 reset accumulators zero");
    @(negedge clk);
    check(rd_valid === 1'b0, "R6 valid drops without request", {255'd0, rd_valid}, '0);

    // table walk: R1 R2 R8
    for (int i = 0; i < N_VEC; i++) begin
      accumulate(gen_vec(W_KIND[i], W_SEED[i]), gen_vec(N_KIND[i], N_SEED[i]));
      read_all("R2 R1 table entry row");
    end

    // R6: read in same cycle as accumulate sees the old row, R8 next read sees new
    begin
      logic [255:0] old_row, w, n;
      old_row = model_row(3);
      w = gen_vec(0, 32'h777); n = gen_vec(0, 32'h31337);
      valid = 1; wide = w; narrow = n; rd_en = 1; rd_row = 3'd3;
      @(posedge clk); @(negedge clk);
      valid = 0; rd_en = 0;
      model_acc(w, n);
      check(rd_valid === 1'b1 && rd_data === old_row, "R6 same-cycle read is pre-update",
            rd_data, old_row);
      read_row(3, "R8 update visible on next read");
    end

    // R4: idle cycles with noisy buses
    for (int i = 0; i < 5; i++) begin
      wide = gen_vec(0, 32'(i) + 32'h900); narrow = gen_vec(0, 32'(i) + 32'ha00);
      @(negedge clk);
    end
    read_all("R4 idle holds accumulators");

    // R3: clear together with valid
    clear = 1; valid = 1; wide = gen_vec(1, 32'h80); narrow = gen_vec(1, 32'h80);
    @(posedge clk); @(negedge clk);
    clear = 0; valid = 0;
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) model[r][c] = '0;
    read_all("R3 clear wins over valid");

    // R5: 32769 maximum products of 65536 wrap past 2^31 to 0x80010000
    valid = 1; wide = gen_vec(1, 32'h80); narrow = gen_vec(1, 32'h80);
    repeat (32769) @(posedge clk);
    @(negedge clk);
    valid = 0;
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) model[r][c] = 32'h80010000;
    read_all("R5 wrap without saturation");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule